// File: doc/BRIEF.md
# Two-Step Time-Exchange Delay and Offset Calculator

This block gathers the four timestamps of one two-step master/slave time exchange and reduces them to the mean path delay and the offset of the slave clock against the master. All timestamps arrive on one strobed bus. Each carries a seconds part, a nanoseconds part, a sequence number and a two-bit role code. The role code says whether the value is the local receive time of a sync message (t2), the master origin time taken from the follow-up message (t1), the local transmit time of a delay request (t3), or the master receive time returned in the delay response (t4).

Every timestamp is turned into a signed 64-bit nanosecond count before any subtraction, so an interval that crosses a second boundary is measured correctly. Once the fourth timestamp of a well-ordered exchange is accepted, the block registers the two results and raises a one-cycle valid pulse. The forward interval is f = t2 − t1 and the reverse interval is r = t4 − t3. The block divides by two with an arithmetic right shift. Message parsing, networking and the servo that applies the correction are left to surrounding logic.

Top module: `ptp_exch_calc`

## Requirements
- R1: While reset is held, and until the first timestamp after reset, `res_vld_o` and `res_neg_err_o` are 0, both result buses are 0, and no exchange is pending.
- R2: An exchange is accepted only in the order sync (role 0), follow-up (role 1), delay request (role 2), delay response (role 3). A follow-up, delay request or delay response that arrives when its step is not the next one expected is ignored.
- R3: A follow-up whose sequence number differs from that of the pending sync is ignored, and the exchange keeps waiting for a matching follow-up.
- R4: The delay request records its own sequence number. A delay response whose sequence number differs from it is ignored.
- R5: A sync strobe in any state starts a new exchange with its own t2 and sequence number, and any partial set is discarded.
- R6: A timestamp's value is seconds × 1,000,000,000 + nanoseconds. The delay result is floor((f + r) / 2), also when an interval crosses a second boundary.
- R7: The offset result is floor((f − r) / 2), rounded toward negative infinity for odd negative values.
- R8: `res_vld_o` is high for exactly the one cycle after the clock edge that accepts a matching delay response. The result buses change only in that cycle and hold their values otherwise.
- R9: `res_neg_err_o` is high together with `res_vld_o` when the delay result is negative, and is low at all other times.
- R10: After a result is produced, the block is idle, and a delay response, follow-up or delay request is ignored until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ts_vld_i | input | 1 | Timestamp strobe |
| ts_role_i | input | 2 | Role: 0 sync rx (t2), 1 follow-up origin (t1), 2 delay-request tx (t3), 3 delay-response rx (t4) |
| ts_seq_i | input | SEQ_W (16) | Sequence number of the message |
| ts_sec_i | input | SEC_W (48) | Seconds part |
| ts_nsec_i | input | NS_W (30) | Nanoseconds part, 0 to 999,999,999 |
| res_vld_o | output | 1 | One-cycle result pulse |
| res_delay_o | output | OUT_W (64) | Mean path delay, two's complement ns |
| res_offset_o | output | OUT_W (64) | Slave-to-master offset, two's complement ns |
| res_neg_err_o | output | 1 | Negative delay flag, qualified by the valid pulse |

## Verification
A timestamp driven in one cycle is taken at the next rising edge. For a matching delay response, the results and the valid pulse are visible right after that same edge, so they are due one cycle after the strobe. The outputs of every other strobe must show no pulse in that cycle. After reset is released, the internal reset release takes two more edges, and the first edge after that is the first active one. The bench's reference model uses the same edge count and is compared with the outputs at every falling edge. The directed checks on the result values are sampled at the falling edge that follows the accepting edge.

// File: rtl/ptp_calc_pkg.sv
package ptp_calc_pkg;

  typedef enum logic [1:0] {
    ROLE_SYNC_RX   = 2'd0,
    ROLE_FU_ORIGIN = 2'd1,
    ROLE_DREQ_TX   = 2'd2,
    ROLE_DRESP_RX  = 2'd3
  } ts_role_e;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_WAIT_FU    = 2'd1,
    ST_WAIT_DREQ  = 2'd2,
    ST_WAIT_DRESP = 2'd3
  } exch_st_e;

  localparam int unsigned NUM_SLOTS = 3;
  localparam int unsigned SLOT_T1   = 0;
  localparam int unsigned SLOT_T2   = 1;
  localparam int unsigned SLOT_T3   = 2;

  localparam longint unsigned NS_PER_SEC = 64'd1000000000;

endpackage

// File: rtl/ptp_ts_to_ns.sv
module ptp_ts_to_ns #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int OUT_W = 64
) (
  input  logic [SEC_W-1:0]        sec_i,
  input  logic [NS_W-1:0]         nsec_i,
  output logic signed [OUT_W-1:0] ns_o
);
  import ptp_calc_pkg::*;

  localparam logic [OUT_W-1:0] SCALE = OUT_W'(NS_PER_SEC);

  logic [OUT_W-1:0] sec_ext;
  logic [OUT_W-1:0] nsec_ext;

  always_comb begin
    sec_ext  = OUT_W'(sec_i);
    nsec_ext = OUT_W'(nsec_i);
    ns_o     = $signed(sec_ext * SCALE + nsec_ext);
  end

endmodule

// File: rtl/ptp_exch_seq.sv
module ptp_exch_seq #(
  parameter int SEQ_W = 16,
  parameter int OUT_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ts_vld_i,
  input  logic [1:0]              ts_role_i,
  input  logic [SEQ_W-1:0]        ts_seq_i,
  input  logic signed [OUT_W-1:0] ts_ns_i,
  output logic signed [OUT_W-1:0] t1_ns_o,
  output logic signed [OUT_W-1:0] t2_ns_o,
  output logic signed [OUT_W-1:0] t3_ns_o,
  output logic                    t4_fire_o
);
  import ptp_calc_pkg::*;

  exch_st_e             st_q, st_d;
  logic [SEQ_W-1:0]     sync_seq_q, sync_seq_d;
  logic [SEQ_W-1:0]     dreq_seq_q, dreq_seq_d;
  logic                 seq_en;
  logic [NUM_SLOTS-1:0] cap_en;
  logic [NUM_SLOTS-1:0][OUT_W-1:0] slot_vec;
  ts_role_e             role;

  assign role = ts_role_e'(ts_role_i);

  // next-state process
  always_comb begin
    st_d       = st_q;
    sync_seq_d = sync_seq_q;
    dreq_seq_d = dreq_seq_q;
    seq_en     = 1'b0;
    cap_en     = '0;
    t4_fire_o  = 1'b0;
    if (ts_vld_i) begin
      unique case (role)
        ROLE_SYNC_RX: begin
          st_d             = ST_WAIT_FU;
          sync_seq_d       = ts_seq_i;
          seq_en           = 1'b1;
          cap_en[SLOT_T2]  = 1'b1;
        end
        ROLE_FU_ORIGIN: begin
          if (st_q == ST_WAIT_FU && ts_seq_i == sync_seq_q) begin
            st_d            = ST_WAIT_DREQ;
            cap_en[SLOT_T1] = 1'b1;
          end
        end
        ROLE_DREQ_TX: begin
          if (st_q == ST_WAIT_DREQ) begin
            st_d            = ST_WAIT_DRESP;
            dreq_seq_d      = ts_seq_i;
            seq_en          = 1'b1;
            cap_en[SLOT_T3] = 1'b1;
          end
        end
        ROLE_DRESP_RX: begin
          if (st_q == ST_WAIT_DRESP && ts_seq_i == dreq_seq_q) begin
            st_d      = ST_IDLE;
            t4_fire_o = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sync_seq_q <= '0;
      dreq_seq_q <= '0;
    end else begin
      st_q <= st_d;
      if (seq_en) begin
        sync_seq_q <= sync_seq_d;
        dreq_seq_q <= dreq_seq_d;
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [OUT_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (cap_en[g]) begin
        q <= ts_ns_i;
      end
    end
    assign slot_vec[g] = q;
  end

  assign t1_ns_o = $signed(slot_vec[SLOT_T1]);
  assign t2_ns_o = $signed(slot_vec[SLOT_T2]);
  assign t3_ns_o = $signed(slot_vec[SLOT_T3]);

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_FU && ts_vld_i && role == ROLE_DREQ_TX) |=> (st_q == ST_WAIT_FU));

  p_fu_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_FU && ts_vld_i && role == ROLE_FU_ORIGIN && ts_seq_i != sync_seq_q)
    |=> (st_q == ST_WAIT_FU));

  p_dresp_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_DRESP && ts_vld_i && role == ROLE_DRESP_RX && ts_seq_i != dreq_seq_q)
    |=> (st_q == ST_WAIT_DRESP));

  p_sync_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_vld_i && role == ROLE_SYNC_RX) |=> (st_q == ST_WAIT_FU && $signed(t2_ns_o) == $past(ts_ns_i)));

  p_idle_after_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    t4_fire_o |=> (st_q == ST_IDLE));

endmodule

// File: rtl/ptp_dly_off_core.sv
module ptp_dly_off_core #(
  parameter int OUT_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    calc_en_i,
  input  logic signed [OUT_W-1:0] t1_ns_i,
  input  logic signed [OUT_W-1:0] t2_ns_i,
  input  logic signed [OUT_W-1:0] t3_ns_i,
  input  logic signed [OUT_W-1:0] t4_ns_i,
  output logic                    res_vld_o,
  output logic signed [OUT_W-1:0] res_delay_o,
  output logic signed [OUT_W-1:0] res_offset_o,
  output logic                    res_neg_err_o
);
  localparam int XW = OUT_W + 2;

  logic signed [XW-1:0]    fwd, rev, sum_w, dif_w;
  logic signed [OUT_W-1:0] dly_d, off_d;
  logic                    vld_d, err_d;

  // next-state process
  always_comb begin
    fwd   = XW'(t2_ns_i) - XW'(t1_ns_i);
    rev   = XW'(t4_ns_i) - XW'(t3_ns_i);
    sum_w = fwd + rev;
    dif_w = fwd - rev;
    vld_d = calc_en_i;
    dly_d = calc_en_i ? OUT_W'(sum_w >>> 1) : res_delay_o;
    off_d = calc_en_i ? OUT_W'(dif_w >>> 1) : res_offset_o;
    err_d = calc_en_i && sum_w[XW-1];
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_o     <= 1'b0;
      res_neg_err_o <= 1'b0;
      res_delay_o   <= '0;
      res_offset_o  <= '0;
    end else begin
      res_vld_o     <= vld_d;
      res_neg_err_o <= err_d;
      if (calc_en_i) begin
        res_delay_o  <= dly_d;
        res_offset_o <= off_d;
      end
    end
  end

  p_vld_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |=> !res_vld_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> ($stable(res_delay_o) && $stable(res_offset_o)));

  p_err_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_neg_err_o |-> (res_vld_o && res_delay_o[OUT_W-1]));

  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_delay_o[OUT_W-1]) |-> res_neg_err_o);

endmodule

// File: rtl/ptp_exch_calc.sv
module ptp_exch_calc #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int SEQ_W = 16,
  parameter int OUT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts_vld_i,
  input  logic [1:0]       ts_role_i,
  input  logic [SEQ_W-1:0] ts_seq_i,
  input  logic [SEC_W-1:0] ts_sec_i,
  input  logic [NS_W-1:0]  ts_nsec_i,
  output logic             res_vld_o,
  output logic [OUT_W-1:0] res_delay_o,
  output logic [OUT_W-1:0] res_offset_o,
  output logic             res_neg_err_o
);

  logic [1:0]              rst_pipe_q;
  logic                    rst_sync_n;
  logic signed [OUT_W-1:0] ts_ns, t1_ns, t2_ns, t3_ns;
  logic signed [OUT_W-1:0] dly_s, off_s;
  logic                    t4_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  ptp_ts_to_ns #(.SEC_W(SEC_W), .NS_W(NS_W), .OUT_W(OUT_W)) u_conv (
    .sec_i  (ts_sec_i),
    .nsec_i (ts_nsec_i),
    .ns_o   (ts_ns)
  );

  ptp_exch_seq #(.SEQ_W(SEQ_W), .OUT_W(OUT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ts_vld_i  (ts_vld_i),
    .ts_role_i (ts_role_i),
    .ts_seq_i  (ts_seq_i),
    .ts_ns_i   (ts_ns),
    .t1_ns_o   (t1_ns),
    .t2_ns_o   (t2_ns),
    .t3_ns_o   (t3_ns),
    .t4_fire_o (t4_fire)
  );

  ptp_dly_off_core #(.OUT_W(OUT_W)) u_core (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .calc_en_i     (t4_fire),
    .t1_ns_i       (t1_ns),
    .t2_ns_i       (t2_ns),
    .t3_ns_i       (t3_ns),
    .t4_ns_i       (ts_ns),
    .res_vld_o     (res_vld_o),
    .res_delay_o   (dly_s),
    .res_offset_o  (off_s),
    .res_neg_err_o (res_neg_err_o)
  );

  assign res_delay_o  = dly_s;
  assign res_offset_o = off_s;

  p_vld_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    t4_fire |=> res_vld_o);

  p_vld_needs_accept_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_vld_o |-> $past(t4_fire));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!res_vld_o && !res_neg_err_o));

endmodule

// File: tb/ptp_exch_calc_tb.sv
`timescale 1ns/1ps
module ptp_exch_calc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts_vld_i = 1'b0;
  logic [1:0]  ts_role_i = 2'd0;
  logic [15:0] ts_seq_i = '0;
  logic [47:0] ts_sec_i = '0;
  logic [29:0] ts_nsec_i = '0;
  logic        res_vld_o, res_neg_err_o;
  logic [63:0] res_delay_o, res_offset_o;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int     rcnt = 0;
  int     m_st = 0;
  int     m_sseq = 0, m_dseq = 0;
  longint m_t1 = 0, m_t2 = 0, m_t3 = 0;
  bit     exp_vld = 1'b0, exp_err = 1'b0;
  longint exp_dly = 0, exp_off = 0;

  always #2 clk = ~clk;

  ptp_exch_calc dut_i (
    .clk(clk), .rst_n(rst_n), .ts_vld_i(ts_vld_i), .ts_role_i(ts_role_i),
    .ts_seq_i(ts_seq_i), .ts_sec_i(ts_sec_i), .ts_nsec_i(ts_nsec_i),
    .res_vld_o(res_vld_o), .res_delay_o(res_delay_o),
    .res_offset_o(res_offset_o), .res_neg_err_o(res_neg_err_o)
  );

  always @(posedge clk) begin
    longint v, f, r;
    if (!rst_n) begin
      rcnt = 0; m_st = 0;
      exp_vld <= 1'b0; exp_err <= 1'b0; exp_dly <= 0; exp_off <= 0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      exp_vld <= 1'b0;
      exp_err <= 1'b0;
      v = longint'(ts_sec_i) * 1000000000 + longint'(ts_nsec_i);
      if (ts_vld_i) begin
        if (ts_role_i == 2'd0) begin
          m_st = 1; m_sseq = int'(ts_seq_i); m_t2 = v;
        end else if (ts_role_i == 2'd1 && m_st == 1 && int'(ts_seq_i) == m_sseq) begin
          m_st = 2; m_t1 = v;
        end else if (ts_role_i == 2'd2 && m_st == 2) begin
          m_st = 3; m_t3 = v; m_dseq = int'(ts_seq_i);
        end else if (ts_role_i == 2'd3 && m_st == 3 && int'(ts_seq_i) == m_dseq) begin
          m_st = 0;
          f = m_t2 - m_t1;
          r = v - m_t3;
          exp_vld <= 1'b1;
          exp_dly <= (f + r) >>> 1;
          exp_off <= (f - r) >>> 1;
          exp_err <= ((f + r) >>> 1) < 0;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "model vld", longint'(res_vld_o), longint'(exp_vld));
      chk(cur_req, "model err", longint'(res_neg_err_o), longint'(exp_err));
      chk(cur_req, "model delay", $signed(res_delay_o), exp_dly);
      chk(cur_req, "model offset", $signed(res_offset_o), exp_off);
    end
  end

  // called at a falling edge; returns at the next falling edge
  task automatic send(input int role, input int seq, input longint sec, input int ns);
    ts_vld_i  = 1'b1;
    ts_role_i = 2'(role);
    ts_seq_i  = 16'(seq);
    ts_sec_i  = 48'(sec);
    ts_nsec_i = 30'(ns);
    @(negedge clk);
    ts_vld_i  = 1'b0;
  endtask

  task automatic expect_res(input string req, input longint d, input longint o, input bit e);
    chk(req, "vld pulse", longint'(res_vld_o), 1);
    chk(req, "delay", $signed(res_delay_o), d);
    chk(req, "offset", $signed(res_offset_o), o);
    chk(req, "neg err", longint'(res_neg_err_o), longint'(e));
  endtask

  task automatic expect_quiet(input string req);
    chk(req, "no pulse", longint'(res_vld_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset vld", longint'(res_vld_o), 0);
    chk("R1", "reset delay", $signed(res_delay_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle delay", $signed(res_delay_o), 0);
    send(3, 0, 1, 1); expect_quiet("R1");

    cur_req = "R6";
    send(0, 1, 100, 1500); send(1, 1, 100, 500);
    send(2, 1, 100, 3000); send(3, 1, 100, 3800);
    expect_res("R6", 900, 100, 0);
    @(negedge clk); expect_quiet("R8");
    chk("R8", "held delay", $signed(res_delay_o), 900);

    cur_req = "R10";
    send(3, 1, 100, 3800); expect_quiet("R10");
    send(1, 1, 100, 500);  expect_quiet("R10");

    cur_req = "R6";
    send(0, 2, 6, 100); send(1, 2, 5, 999999900);
    send(2, 2, 6, 999999950); send(3, 2, 7, 150);
    expect_res("R6", 200, 0, 0);

    cur_req = "R7";
    send(0, 3, 200, 101); send(1, 3, 200, 0);
    send(2, 3, 200, 1000); send(3, 3, 200, 1300);
    expect_res("R7", 200, -100, 0);

    cur_req = "R9";
    send(0, 4, 300, 500); send(1, 4, 300, 1000);
    send(2, 4, 300, 2000); send(3, 4, 300, 2100);
    expect_res("R9", -200, -300, 1);
    @(negedge clk);
    chk("R9", "err cleared", longint'(res_neg_err_o), 0);

    cur_req = "R3";
    send(0, 10, 400, 1000); send(1, 11, 400, 0);
    send(2, 10, 400, 5000); send(3, 10, 400, 5200); expect_quiet("R3");
    send(1, 10, 400, 600); send(2, 10, 400, 5000); send(3, 10, 400, 5200);
    expect_res("R3", 300, 100, 0);

    cur_req = "R4";
    send(0, 20, 500, 1000); send(1, 20, 500, 0); send(2, 21, 500, 2000);
    send(3, 22, 500, 9000); expect_quiet("R4");
    send(3, 21, 500, 2400);
    expect_res("R4", 700, 300, 0);

    cur_req = "R2";
    send(0, 30, 600, 800); send(2, 30, 600, 100); send(3, 30, 600, 150);
    expect_quiet("R2");
    send(1, 30, 600, 0); send(3, 30, 600, 150); expect_quiet("R2");
    send(2, 30, 600, 1000); send(1, 30, 600, 999); send(3, 30, 600, 1200);
    expect_res("R2", 500, 300, 0);

    cur_req = "R5";
    send(0, 40, 700, 500); send(1, 40, 700, 0);
    send(0, 41, 700, 2000); send(2, 41, 700, 2500); expect_quiet("R5");
    send(1, 41, 700, 1000); send(2, 41, 700, 3000); send(3, 41, 700, 3000);
    expect_res("R5", 500, 500, 0);
    send(0, 42, 800, 10); send(1, 42, 800, 0); send(2, 42, 800, 50);
    send(0, 43, 800, 20); send(3, 42, 800, 60); expect_quiet("R5");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule